// File: doc/BRIEF.md
# Hybrid-Way Cache Swap Controller

This controller runs a set-associative L1 data cache in which every set has one fast static way and several slow dynamic ways. The static way always holds the line used most recently in its set. Reading a dynamic way destroys its contents, so the controller never reads dynamic data on a guess. On each load it compares the tags of every way in the set and reads only the static way's data. A static hit answers at once. A dynamic hit first reads the chosen dynamic way and then answers. A miss sends a fill request to the next level and answers when the fill data arrives.

Once the processor has its data, a dynamic hit or a miss is followed by a swap. The data for the requested line is already in a holding buffer. The old static line moves into a dynamic way, and the requested line then moves into the static way. Dynamic storage is never refreshed on a timer. Each dynamic line has its own age counter. A line that is left untouched for the retention window counts as absent and is fetched again from the next level. The processor port uses valid/ready handshaking. The fill port is a plain request/acknowledge pair.

Top module: `hybrid_way_cache_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, while `resp_valid` and `fill_req_valid` are 0 and no way holds a line.
- R2: A load whose tag matches the static way of its set sets `resp_valid` with the line data one cycle after it is accepted. It raises no fill request and leaves `req_ready` high.
- R3: A load whose tag matches a live dynamic way sets `resp_valid` with that line's data two cycles after it is accepted, and it raises no fill request.
- R4: A load that finds no live matching way drives `fill_req_valid` with `fill_addr` equal to the request address. `resp_valid` with `fill_data` follows in the cycle after `fill_valid` is sampled high.
- R5: After a dynamic-hit or miss response, `req_ready` stays low for exactly two more cycles, one to demote and one to promote, and then goes high again.
- R6: After the swap, the requested line hits in the static way. The line that was static before hits in a dynamic way.
- R7: On a miss, the old static line goes to the dynamic way named by a per-set pointer. The pointer starts at way 0 and steps 0, 1, …, WAYS-2 and back to 0 on each miss in that set. Dynamic hits leave it unchanged. The line previously held in that way is discarded.
- R8: A dynamic line counts as absent once RETAIN or more cycles have passed since it was written, and a load to it is then a miss. A line in the static way never expires. No refresh is issued on a timer.
- R9: Each accepted load produces exactly one `resp_valid` pulse, and at most one load is outstanding at a time.
- R10: `fill_req_valid` stays high with a stable `fill_addr` until `fill_valid` is seen, and it is never high while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Controller can accept a load |
| req_addr | input | ADDR_W | Line address; the low bits select the set and the rest form the tag |
| resp_valid | output | 1 | One-cycle pulse carrying load data |
| resp_data | output | DATA_W | Load data |
| fill_req_valid | output | 1 | Fill request to the next level |
| fill_addr | output | ADDR_W | Address being filled |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | DATA_W | Line returned by the next level |

## Verification
The bound checker watches properties that hold on every cycle. It checks one outstanding load and one response per load, that the fill request is held with a steady address, that a response follows the accepted fill, and that a slow response is followed by exactly two busy cycles. Which way a load should hit, its exact latency and the data it returns depend on the history of the set. Only directed scenarios can show these: promotion and demotion of a line, the rotating choice of victim with its discarded line, and a dynamic line expiring while an idle static line stays valid.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREAD,
    ST_FILL,
    ST_DEMOTE,
    ST_PROMOTE
  } hwc_state_e;
endpackage

// File: rtl/hwc_lookup.sv
// Tag compare for one set: static way plus every dynamic way in parallel.
module hwc_lookup #(
  parameter int TAG_W = 12,
  parameter int DWAYS = 3,
  parameter int DW_W  = 2
) (
  input  logic [TAG_W-1:0]       probe,
  input  logic                   s_val,
  input  logic [TAG_W-1:0]       s_tag,
  input  logic [DWAYS-1:0]       d_val,
  input  logic [DWAYS-1:0]       d_exp,
  input  logic [DWAYS*TAG_W-1:0] d_tags,
  output logic                   s_hit,
  output logic                   d_hit,
  output logic [DW_W-1:0]        d_way
);
  logic [DWAYS-1:0] match;

  genvar g;
  generate
    for (g = 0; g < DWAYS; g++) begin : g_cmp
      assign match[g] = d_val[g] && !d_exp[g] && (d_tags[g*TAG_W +: TAG_W] == probe);
    end
  endgenerate

  assign s_hit = s_val && (s_tag == probe);
  assign d_hit = |match;

  always_comb begin
    d_way = '0;
    for (int w = DWAYS - 1; w >= 0; w--) begin
      if (match[w]) d_way = DW_W'(w);
    end
  end
endmodule

// File: rtl/hwc_age_bank.sv
// One saturating age counter per dynamic line; saturated means expired.
module hwc_age_bank #(
  parameter int LINES  = 48,
  parameter int SLOT_W = 6,
  parameter int RETAIN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_slot,
  output logic [LINES-1:0]  expired
);
  localparam int AGE_W = $clog2(RETAIN + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(RETAIN);

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [AGE_W-1:0] age;
      always_ff @(posedge clk) begin
        if (rst) begin
          age <= AGE_MAX;
        end else if (clr_en && (clr_slot == SLOT_W'(g))) begin
          age <= '0;
        end else if (age != AGE_MAX) begin
          age <= age + 1'b1;
        end
      end
      assign expired[g] = (age == AGE_MAX);
    end
  endgenerate
endmodule

// File: rtl/hwc_victim_ptr.sv
// Per-set rotating pointer that picks the dynamic way receiving a demoted line on a miss.
module hwc_victim_ptr #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int DWAYS = 3,
  parameter int DW_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_en,
  input  logic [IDX_W-1:0] set_sel,
  output logic [DW_W-1:0]  way
);
  logic [DW_W-1:0] ptr [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) ptr[s] <= '0;
    end else if (adv_en) begin
      ptr[set_sel] <= (ptr[set_sel] == DW_W'(DWAYS - 1)) ? '0 : ptr[set_sel] + 1'b1;
    end
  end

  assign way = ptr[set_sel];
endmodule

// File: rtl/hybrid_way_cache_ctrl.sv
module hybrid_way_cache_ctrl
  import hwc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int RETAIN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int DWAYS  = WAYS - 1;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int DW_W   = (DWAYS > 1) ? $clog2(DWAYS) : 1;
  localparam int LINES  = SETS * DWAYS;
  localparam int SLOT_W = (LINES > 1) ? $clog2(LINES) : 1;

  function automatic logic [SLOT_W-1:0] slot_of(input logic [IDX_W-1:0] i,
                                                 input logic [DW_W-1:0] w);
    return SLOT_W'(i) * SLOT_W'(DWAYS) + SLOT_W'(w);
  endfunction

  // Static way storage (one line per set)
  logic [DATA_W-1:0] s_data [SETS];
  logic [TAG_W-1:0]  s_tag  [SETS];
  logic [SETS-1:0]   s_val;
  // Dynamic way storage (DWAYS lines per set, flattened)
  logic [DATA_W-1:0] d_data [LINES];
  logic [TAG_W-1:0]  d_tag  [LINES];
  logic [LINES-1:0]  d_val;
  logic [LINES-1:0]  d_expired;

  hwc_state_e        state;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [DW_W-1:0]   cur_way;
  logic [DATA_W-1:0] hold_buf;
  logic [SLOT_W-1:0] cur_slot;

  logic [IDX_W-1:0]       a_idx;
  logic [TAG_W-1:0]       a_tag;
  logic [DWAYS*TAG_W-1:0] set_dtag;
  logic [DWAYS-1:0]       set_dval;
  logic [DWAYS-1:0]       set_dexp;
  logic                   s_hit, d_hit;
  logic [DW_W-1:0]        hit_way;
  logic [DW_W-1:0]        vic_way;
  logic                   accept;

  assign a_idx     = req_addr[IDX_W-1:0];
  assign a_tag     = req_addr[ADDR_W-1:IDX_W];
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cur_slot  = slot_of(cur_idx, cur_way);

  always_comb begin
    for (int w = 0; w < DWAYS; w++) begin
      set_dtag[w*TAG_W +: TAG_W] = d_tag[slot_of(a_idx, DW_W'(w))];
      set_dval[w]                = d_val[slot_of(a_idx, DW_W'(w))];
      set_dexp[w]                = d_expired[slot_of(a_idx, DW_W'(w))];
    end
  end

  hwc_lookup #(.TAG_W(TAG_W), .DWAYS(DWAYS), .DW_W(DW_W)) u_lookup (
    .probe  (a_tag),
    .s_val  (s_val[a_idx]),
    .s_tag  (s_tag[a_idx]),
    .d_val  (set_dval),
    .d_exp  (set_dexp),
    .d_tags (set_dtag),
    .s_hit  (s_hit),
    .d_hit  (d_hit),
    .d_way  (hit_way)
  );

  hwc_age_bank #(.LINES(LINES), .SLOT_W(SLOT_W), .RETAIN(RETAIN)) u_age (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (state == ST_DEMOTE),
    .clr_slot (cur_slot),
    .expired  (d_expired)
  );

  hwc_victim_ptr #(.SETS(SETS), .IDX_W(IDX_W), .DWAYS(DWAYS), .DW_W(DW_W)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .adv_en  (accept && !s_hit && !d_hit),
    .set_sel (a_idx),
    .way     (vic_way)
  );

  // Control path
  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      resp_valid     <= 1'b0;
      fill_req_valid <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (s_hit) begin
              resp_valid <= 1'b1;
            end else if (d_hit) begin
              state <= ST_DREAD;
            end else begin
              state          <= ST_FILL;
              fill_req_valid <= 1'b1;
            end
          end
        end
        ST_DREAD: begin
          resp_valid <= 1'b1;
          state      <= ST_DEMOTE;
        end
        ST_FILL: begin
          if (fill_valid) begin
            resp_valid     <= 1'b1;
            fill_req_valid <= 1'b0;
            state          <= ST_DEMOTE;
          end
        end
        ST_DEMOTE:  state <= ST_PROMOTE;
        ST_PROMOTE: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  // Datapath registers (no reset needed)
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && accept) begin
      cur_idx   <= a_idx;
      cur_tag   <= a_tag;
      cur_way   <= d_hit ? hit_way : vic_way;
      fill_addr <= req_addr;
      if (s_hit) resp_data <= s_data[a_idx];
    end
    if (state == ST_DREAD) begin
      hold_buf  <= d_data[cur_slot];
      resp_data <= d_data[cur_slot];
    end
    if (state == ST_FILL && fill_valid) begin
      hold_buf  <= fill_data;
      resp_data <= fill_data;
    end
  end

  // Line storage: swap step two writes the dynamic way, step three the static way
  always_ff @(posedge clk) begin
    if (state == ST_DEMOTE) begin
      d_data[cur_slot] <= s_data[cur_idx];
      d_tag[cur_slot]  <= s_tag[cur_idx];
    end
    if (state == ST_PROMOTE) begin
      s_data[cur_idx] <= hold_buf;
      s_tag[cur_idx]  <= cur_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_val <= '0;
      d_val <= '0;
    end else begin
      if (state == ST_DREAD)   d_val[cur_slot] <= 1'b0;  // read is destructive
      if (state == ST_DEMOTE)  d_val[cur_slot] <= s_val[cur_idx];
      if (state == ST_PROMOTE) s_val[cur_idx]  <= 1'b1;
    end
  end
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              fill_req_valid,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr
);
  logic [1:0] pend;
  logic       prev_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 2'd0;
      prev_ready <= 1'b1;
    end else begin
      pend       <= pend + {1'b0, (req_valid && req_ready)} - {1'b0, resp_valid};
      prev_ready <= req_ready;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    pend <= 2'd1);  // R9
  AST_RESP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (pend == 2'd1));  // R9
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid && !fill_valid) |=> (fill_req_valid && $stable(fill_addr)));  // R10
  AST_FILL_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    fill_req_valid |-> !req_ready);  // R10
  AST_FILL_TO_RESP: assert property (@(posedge clk) disable iff (rst)
    (fill_req_valid && fill_valid) |=> (resp_valid && !fill_req_valid));  // R4
  AST_SWAP_BUSY: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !prev_ready) |-> !req_ready);  // R5
  AST_SWAP_LEN: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !prev_ready) |=> (!req_ready && !resp_valid));  // R5
endmodule

bind hybrid_way_cache_ctrl hwc_checker #(.ADDR_W(ADDR_W)) u_hwc_checker (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .resp_valid     (resp_valid),
  .fill_req_valid (fill_req_valid),
  .fill_valid     (fill_valid),
  .fill_addr      (fill_addr)
);

// File: tb/tb_hybrid_way_cache_ctrl.sv
module tb_hybrid_way_cache_ctrl;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int RETAIN = 200;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              resp_valid;
  logic [DATA_W-1:0] resp_data;
  logic              fill_req_valid;
  logic [ADDR_W-1:0] fill_addr;
  logic              fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hybrid_way_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(4), .SETS(16), .RETAIN(RETAIN)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_data(resp_data), .fill_req_valid(fill_req_valid),
    .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data)
  );

  function automatic logic [DATA_W-1:0] mem(input logic [ADDR_W-1:0] a);
    return {a, a ^ 16'hA5C3};
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
    return {tag[11:0], idx[3:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Next-level model: answers a fill on the third cycle it is seen
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (fill_valid) begin
        fill_valid = 1'b0;
      end else if (fill_req_valid) begin
        cnt++;
        if (cnt == 3) begin
          fill_valid = 1'b1;
          fill_data  = mem(fill_addr);
          cnt = 0;
        end
      end
    end
  end

  // kind: 0 static hit, 1 dynamic hit, 2 miss
  task automatic rd(input logic [ADDR_W-1:0] a, input int kind, input string req);
    int lat;
    bit fill_seen;
    bit addr_ok;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    fill_seen = 1'b0;
    addr_ok = 1'b1;
    while (!resp_valid && lat < 100) begin
      if (fill_req_valid) begin
        fill_seen = 1'b1;
        if (fill_addr != a) addr_ok = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    chk(resp_data == mem(a), {req, " data"}, resp_data, mem(a));
    if (kind == 0) begin
      chk(lat == 1, {req, " static latency"}, lat, 1);
      chk(!fill_seen, {req, " static no fill"}, fill_seen, 0);
      chk(req_ready, {req, " static ready"}, req_ready, 1);
    end else begin
      if (kind == 1) begin
        chk(lat == 2, {req, " dynamic latency"}, lat, 2);
        chk(!fill_seen, {req, " dynamic no fill"}, fill_seen, 0);
      end else begin
        chk(fill_seen && addr_ok, {req, " miss fill address"}, {fill_seen, addr_ok}, 2'b11);
        chk(lat == 4, {req, " miss latency"}, lat, 4);
      end
      chk(!req_ready, "R5 busy at response", req_ready, 0);
      @(negedge clk);
      chk(!req_ready && !resp_valid, "R5 busy during swap", {req_ready, resp_valid}, 0);
      @(negedge clk);
      chk(req_ready && !resp_valid, "R5 ready after swap", {req_ready, resp_valid}, 1);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !resp_valid && !fill_req_valid, "R1 reset outputs",
        {req_ready, resp_valid, fill_req_valid}, 3'b100);
    rd(mk(9, 5), 2, "R1 empty after reset");
  endtask

  task automatic t_promote();
    rd(mk(1, 0), 2, "R4 cold miss");
    rd(mk(1, 0), 0, "R2 static hit");
    rd(mk(1, 0), 0, "R2 repeat static hit");
    rd(mk(2, 0), 2, "R4 second miss");
    rd(mk(1, 0), 1, "R6 demoted line dynamic hit");
    rd(mk(1, 0), 0, "R6 promoted line static");
    rd(mk(2, 0), 1, "R3 dynamic hit");
    rd(mk(2, 0), 0, "R9 single response then static");
  endtask

  task automatic t_rotate();
    for (int t = 0; t < 4; t++) rd(mk(20 + t, 1), 2, "R7 fill set");
    rd(mk(22, 1), 1, "R7 hit C2");
    rd(mk(21, 1), 1, "R7 hit C1");
    rd(mk(20, 1), 1, "R7 hit C0");
    rd(mk(24, 1), 2, "R7 miss C4");
    rd(mk(21, 1), 2, "R7 C1 discarded");
    rd(mk(23, 1), 1, "R7 C3 kept");
    rd(mk(22, 1), 2, "R7 C2 discarded");
  endtask

  task automatic t_retain();
    rd(mk(5, 2), 2, "R8 load E");
    rd(mk(6, 2), 2, "R8 load F");
    repeat (RETAIN + 300) @(negedge clk);
    rd(mk(6, 2), 0, "R8 static never expires");
    rd(mk(5, 2), 2, "R8 expired dynamic refetch");
    rd(mk(7, 3), 2, "R8 load G");
    rd(mk(8, 3), 2, "R8 load H");
    repeat (RETAIN * 3 / 4) @(negedge clk);
    rd(mk(7, 3), 1, "R8 G still live");
    repeat (RETAIN * 3 / 4) @(negedge clk);
    rd(mk(8, 3), 1, "R8 H refreshed by swap");
  endtask

  initial begin
    t_reset();
    t_promote();
    t_rotate();
    t_retain();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule